// File: doc/BRIEF.md
# Multiplier-Free Polyphase Decimator (Order 4, Rate 64)

This block is the first rate-reduction stage behind a sigma-delta modulator. It takes a stream of narrow signed samples and applies a fourth-order boxcar (sinc^4) response with an overall rate reduction of 64. The usual integrator/comb pair is not used. The response is factored into six identical half-rate sections. Each section applies the binomial kernel 1-4-6-4-1 and keeps one sample in two.

Each section is split into two polyphase branches. One branch sums the odd-position samples with weights 1, 6, 1. The other sums the even-position samples with weights 4, 4. Both branches use only shifts and adds. Their delay lines advance once per output, so each section works at its own output rate and no accumulator grows without bound. The word grows by four bits per section, so a 4-bit input gives a 28-bit full-precision result. Samples arrive with a valid strobe, and gaps between them are allowed.

Top module: `cic_poly_decim`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `out_valid` is 0 and `out_sample` is 0.
- R2: Exactly one single-cycle `out_valid` pulse is issued for every 64 accepted samples, counted from reset. The pulse is visible after the sixth rising edge, where the first of those six edges is the one that accepts the 64th sample of the group.
- R3: `in_sample` is a 4-bit two's-complement value. Output k equals y[64k+63], where y is the input passed through four cascaded length-64 moving sums with all history zero at reset. The result is a 28-bit two's-complement value.
- R4: A constant input x gives an output of exactly x·2^24 from the fourth output after reset onward. This includes x = -8, which gives -2^27.
- R5: Cycles with `in_valid` low are ignored: `in_sample` on those cycles does not affect any output value or pulse timing.
- R6: `out_sample` holds its value on every cycle that `out_valid` is low, and `out_valid` is never high on two consecutive cycles.
- R7: A reset that arrives partway through a group discards the partial group and all filter history. Later outputs match R3 with the sample count restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_sample` on this cycle |
| in_sample | input | 4 | Two's-complement input sample |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| out_sample | output | 28 | Two's-complement decimated result, held between strobes |

## Verification
The assertions take for granted that `in_valid` is a clean, known signal after reset. They also assume that samples are counted from reset only, with no other way to restart a group. The stimulus keeps within this by changing inputs only at the falling edge, by leaving `in_valid` low during reset, and by restarting the bench model at every reset. Any input value is legal, so the stimulus sweeps all sixteen codes as constants. It also drives garbage onto `in_sample` during idle cycles, so that ignoring those cycles is actually tested.

// File: rtl/cic_pkg.sv
// Shared constants and width helpers for the polyphase decimator.
// Assumes every section applies a fourth-order binomial kernel, so the
// word grows by CIC_ORDER bits (gain 16) per half-rate section.
package cic_pkg;

    localparam int CIC_ORDER = 4;

    // Width of the word leaving section idx (idx = 0 is the raw input).
    function automatic int stage_w(input int in_w, input int idx);
        return in_w + CIC_ORDER * idx;
    endfunction

endpackage

// File: rtl/cic_even_taps.sv
// Branch holding the odd-position samples of a pair window: newest, one
// pair back, two pairs back, weighted 1, 6, 1. Only shifts and adds are used.
// Assumes W_OUT >= W_IN + 3, so the sum cannot overflow.
module cic_even_taps #(
    parameter int W_IN  = 4,
    parameter int W_OUT = W_IN + 4
) (
    input  logic signed [W_IN-1:0]  newest,
    input  logic signed [W_IN-1:0]  mid,
    input  logic signed [W_IN-1:0]  oldest,
    output logic signed [W_OUT-1:0] sum_o
);

    logic signed [W_OUT-1:0] n_x;
    logic signed [W_OUT-1:0] m_x;
    logic signed [W_OUT-1:0] o_x;

    // Sign-extend the branch samples to the result width.
    always_comb begin
        n_x = W_OUT'(newest);
        m_x = W_OUT'(mid);
        o_x = W_OUT'(oldest);
    end

    // Weight six is formed as four plus two.
    assign sum_o = n_x + (m_x <<< 2) + (m_x <<< 1) + o_x;

endmodule

// File: rtl/cic_odd_taps.sv
// Branch holding the even-position samples of a pair window, both weighted 4.
// Assumes W_OUT >= W_IN + 3.
module cic_odd_taps #(
    parameter int W_IN  = 4,
    parameter int W_OUT = W_IN + 4
) (
    input  logic signed [W_IN-1:0]  recent,
    input  logic signed [W_IN-1:0]  older,
    output logic signed [W_OUT-1:0] sum_o
);

    logic signed [W_OUT-1:0] pair;

    // Add the two samples at full width, then scale by four.
    always_comb begin
        pair  = W_OUT'(recent) + W_OUT'(older);
        sum_o = pair <<< 2;
    end

endmodule

// File: rtl/cic_pair_stage.sv
// One half-rate section: applies 1-4-6-4-1 and keeps one sample of two.
// The two polyphase delay lines each advance once per output. The output
// word is registered, held between strobes, and strobed for one cycle on the
// cycle after the second sample of each pair is accepted.
// Assumes in_valid is never high on a cycle where the section must stall
// (this section accepts one sample per cycle without back-pressure).
module cic_pair_stage #(
    parameter int W_IN  = 4,
    parameter int W_OUT = W_IN + cic_pkg::CIC_ORDER
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [W_IN-1:0]  in_data,
    output logic                    out_valid,
    output logic signed [W_OUT-1:0] out_data
);

    logic                   phase;
    logic signed [W_IN-1:0] ev_d1;
    logic signed [W_IN-1:0] ev_d2;
    logic signed [W_IN-1:0] od_d0;
    logic signed [W_IN-1:0] od_d1;
    logic signed [W_OUT-1:0] ev_sum;
    logic signed [W_OUT-1:0] od_sum;

    cic_even_taps #(.W_IN(W_IN), .W_OUT(W_OUT)) u_even (
        .newest (in_data),
        .mid    (ev_d1),
        .oldest (ev_d2),
        .sum_o  (ev_sum)
    );

    cic_odd_taps #(.W_IN(W_IN), .W_OUT(W_OUT)) u_odd (
        .recent (od_d0),
        .older  (od_d1),
        .sum_o  (od_sum)
    );

    // Route each accepted sample to its branch and emit on pair completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= 1'b0;
            ev_d1     <= '0;
            ev_d2     <= '0;
            od_d0     <= '0;
            od_d1     <= '0;
            out_data  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (in_valid) begin
                phase <= ~phase;
                if (!phase) begin
                    od_d1 <= od_d0;
                    od_d0 <= in_data;
                end else begin
                    ev_d2     <= ev_d1;
                    ev_d1     <= in_data;
                    out_data  <= ev_sum + od_sum;
                    out_valid <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/cic_poly_decim.sv
// Fourth-order rate-64 decimator built as a chain of DECIM_LOG2 half-rate
// binomial sections. The output carries full precision: IN_W + 4*DECIM_LOG2
// bits. Assumes in_sample is two's complement and qualified by in_valid.
module cic_poly_decim #(
    parameter int IN_W       = 4,
    parameter int DECIM_LOG2 = 6,
    parameter int OUT_W      = cic_pkg::stage_w(IN_W, DECIM_LOG2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_sample,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_sample
);

    logic [DECIM_LOG2:0] vld_chain;

    assign vld_chain[0] = in_valid;

    // One section per factor of two; widths grow along the chain.
    for (genvar s = 0; s < DECIM_LOG2; s++) begin : g_stage
        localparam int WI = cic_pkg::stage_w(IN_W, s);
        localparam int WO = cic_pkg::stage_w(IN_W, s + 1);

        logic signed [WI-1:0] stage_in;
        logic signed [WO-1:0] stage_out;

        if (s == 0) begin : g_head
            assign stage_in = in_sample;
        end else begin : g_link
            assign stage_in = g_stage[s-1].stage_out;
        end

        cic_pair_stage #(.W_IN(WI), .W_OUT(WO)) u_sec (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (vld_chain[s]),
            .in_data   (stage_in),
            .out_valid (vld_chain[s+1]),
            .out_data  (stage_out)
        );
    end

    assign out_valid  = vld_chain[DECIM_LOG2];
    assign out_sample = g_stage[DECIM_LOG2-1].stage_out;

endmodule

// File: rtl/cic_decim_checker.sv
// Protocol checks on the decimator ports, attached by bind.
// Assumes in_valid is known after reset and groups count from reset only.
module cic_decim_checker #(
    parameter int OUT_W = 28,
    parameter int GROUP = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_sample
);

    localparam int CW = (GROUP > 1) ? $clog2(GROUP) : 1;

    logic [CW-1:0] in_cnt;
    logic [31:0]   groups_done;
    logic [31:0]   outs_seen;
    logic          was_reset;
    logic          run_q;

    // Count completed input groups and emitted strobes since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_cnt      <= '0;
            groups_done <= '0;
            outs_seen   <= '0;
        end else begin
            if (in_valid) begin
                if (32'(in_cnt) == GROUP - 1) begin
                    in_cnt      <= '0;
                    groups_done <= groups_done + 32'd1;
                end else begin
                    in_cnt <= in_cnt + 1'b1;
                end
            end
            if (out_valid) outs_seen <= outs_seen + 32'd1;
        end
    end

    // Remember whether reset was held on the previous edge.
    always_ff @(posedge clk) begin
        was_reset <= !rst_n;
        run_q     <= rst_n;
    end

    // R1: outputs are cleared on the cycle after a reset edge.
    always_ff @(posedge clk) begin
        if (was_reset) begin
            a_r1_reset_clears: assert (!out_valid && out_sample == '0)
                else $error("R1 outputs not cleared after reset");
        end
    end

    // R2: never more strobes than completed groups.
    a_r2_strobe_budget: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (outs_seen < groups_done));

    // R6: strobes last one cycle.
    a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R6: result word is held while no strobe is present.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && run_q) |-> $stable(out_sample));

endmodule

bind cic_poly_decim cic_decim_checker #(
    .OUT_W (OUT_W),
    .GROUP (1 << DECIM_LOG2)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .out_valid  (out_valid),
    .out_sample (out_sample)
);

// File: tb/tb_cic_poly_decim.sv
// Self-checking bench: an arithmetic model of four cascaded length-64
// moving sums, compared against every strobe, plus timing and hold checks.
module tb_cic_poly_decim;

    localparam int IN_W  = 4;
    localparam int OUT_W = 28;
    localparam int GROUP = 64;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [IN_W-1:0]  in_sample = '0;
    logic             out_valid;
    logic [OUT_W-1:0] out_sample;

    cic_poly_decim dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

    always #4 clk = ~clk;

    int     checks = 0;
    int     errors = 0;
    longint edge_cnt = 0;
    bit     mon_en = 0;
    bit     const_mode = 0;
    int     const_val = 0;
    int     out_idx = 0;
    string  cur_tag = "R3";
    logic [OUT_W-1:0] last_out = '0;
    logic [15:0] lfsr = 16'hACE1;

    longint acc [4];
    longint hist [4][GROUP];
    int     ptr = 0;
    longint exp_q [$];
    longint edge_q [$];

    always @(posedge clk) edge_cnt <= edge_cnt + 1;

    // Record one check and print a FAIL line on mismatch.
    task automatic check(input string tag, input longint act, input longint expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Clear the reference model to zero history.
    task automatic model_clear();
        for (int j = 0; j < 4; j++) begin
            acc[j] = 0;
            for (int i = 0; i < GROUP; i++) hist[j][i] = 0;
        end
        ptr = 0;
        exp_q.delete();
        edge_q.delete();
    endtask

    // Advance the reference by one accepted sample taken at edge tk.
    task automatic model_push(input int v, input longint tk);
        longint x;
        x = v;
        for (int j = 0; j < 4; j++) begin
            acc[j] = acc[j] + x - hist[j][ptr];
            hist[j][ptr] = x;
            x = acc[j];
        end
        if (ptr == GROUP - 1) begin
            exp_q.push_back(x);
            edge_q.push_back(tk + 5);
        end
        ptr = (ptr + 1) % GROUP;
    endtask

    function automatic logic [15:0] lfsr_next(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    // Reset the design and the model, then check the cleared outputs (R1).
    task automatic do_reset();
        mon_en = 0;
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_clear();
        out_idx = 0;
        last_out = '0;
        check("R1 out_valid", longint'(out_valid), 0);
        check("R1 out_sample", longint'($signed(out_sample)), 0);
        @(negedge clk);
        check("R1 out_valid after release", longint'(out_valid), 0);
        check("R1 out_sample after release", longint'($signed(out_sample)), 0);
        mon_en = 1;
    endtask

    // Present one sample; with gaps on, idle cycles carry garbage data (R5).
    task automatic feed(input int v, input bit gaps);
        if (gaps) begin
            lfsr = lfsr_next(lfsr);
            while (lfsr[0]) begin
                @(negedge clk);
                in_valid  = 1'b0;
                in_sample = lfsr[7:4];
                lfsr = lfsr_next(lfsr);
            end
        end
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = v[IN_W-1:0];
        model_push(v, edge_cnt + 1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Compare each strobe with the model and check holding between strobes.
    always @(negedge clk) begin
        if (mon_en && rst_n) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check("R2 unexpected strobe", 1, 0);
                end else begin
                    longint e;
                    longint te;
                    e  = exp_q.pop_front();
                    te = edge_q.pop_front();
                    check(cur_tag, longint'($signed(out_sample)), e);
                    check("R2 strobe edge", edge_cnt, te);
                    if (const_mode && out_idx >= 3)
                        check("R4 dc gain", longint'($signed(out_sample)),
                              longint'(const_val) * (longint'(1) << 24));
                end
                out_idx++;
                last_out = out_sample;
            end else begin
                check("R6 hold", longint'($signed(out_sample)),
                      longint'($signed(last_out)));
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model_clear();
        do_reset();

        // R3: impulse response over five groups.
        cur_tag = "R3 impulse";
        feed(1, 0);
        for (int i = 1; i < 5 * GROUP; i++) feed(0, 0);
        idle(10);

        // R4: every input code held constant, starting from reset.
        for (int v = -8; v <= 7; v++) begin
            do_reset();
            const_mode = 1;
            const_val  = v;
            cur_tag    = "R4 constant model";
            for (int i = 0; i < 5 * GROUP; i++) feed(v, 0);
            idle(10);
            const_mode = 0;
        end

        // R3: alternating extremes and a ramp through all codes.
        do_reset();
        cur_tag = "R3 alternating";
        for (int i = 0; i < 4 * GROUP; i++) feed((i % 2) ? -8 : 7, 0);
        cur_tag = "R3 ramp";
        for (int i = 0; i < 4 * GROUP; i++) feed((i % 16) - 8, 0);
        idle(10);

        // R5: pseudo-random samples with idle gaps carrying garbage.
        cur_tag = "R5 gaps";
        for (int i = 0; i < 40 * GROUP; i++) begin
            lfsr = lfsr_next(lfsr);
            feed(int'($signed(lfsr[11:8])), 1);
        end
        idle(10);

        // R7: reset in the middle of a group, then resume.
        for (int i = 0; i < 37; i++) feed(7, 0);
        do_reset();
        cur_tag = "R7 after mid reset";
        for (int i = 0; i < 4 * GROUP; i++) begin
            lfsr = lfsr_next(lfsr);
            feed(int'($signed(lfsr[3:0])), 0);
        end
        idle(12);

        // R2: every expected strobe must have arrived.
        check("R2 pending strobes", exp_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule